// File: doc/BRIEF.md
# Pipelined Sorted-Set Intersection Node

This block takes two sets of rule identifiers, each already sorted ascending and free of repeats, and returns the identifiers that occur in both. Each set arrives as a fixed number of slots, K/2. Slots not holding an identifier carry a sentinel, the all-ones value, and they sit after the real entries. The result uses the same format: matching identifiers fill the lowest slots in ascending order, each with a hit flag, and the remaining slots hold the sentinel. A result can therefore go straight into a second node of the same kind, so several such nodes can reduce the per-field candidate lists of a multi-field classifier to the rules that match in every field.

Inside, the second set is reversed and placed after the first. Together they form a bitonic sequence of K values. A bitonic merge network of log2(K) registered compare-exchange stages sorts this sequence. The first stage compares values K/2 apart, and each later stage halves that distance. After the merge, any identifier present in both sets occupies two neighbouring positions. A registered neighbour checker finds these equal pairs, ignores pairs of sentinels, and packs the matches into the low output slots. The node accepts a new pair of sets on every clock.

Top module: `bmi_node`

## Requirements
- R1: While reset is held, and in every cycle where `out_valid` is low, `out_hit` is all zeros and every slot of `out_ids` holds the all-ones sentinel.
- R2: Each cycle with `in_valid` high produces exactly one result. That result has `out_valid` high exactly log2(K)+1 clocks after the sampling edge (4 clocks for K=8).
- R3: The number of set bits in `out_hit` equals the number of identifiers common to `set_a` and `set_b`.
- R4: Common identifiers occupy output slots 0 upward in strictly ascending order, and `out_hit` is set for exactly those slots. Slot n is bits [n*ID_W +: ID_W].
- R5: Every output slot whose `out_hit` bit is clear holds the all-ones sentinel.
- R6: Sentinel slots never produce a match, even when both inputs contain sentinels. Two empty sets give zero hits.
- R7: A new pair may be presented on every consecutive clock. Each result depends only on its own pair.
- R8: Two identical full sets return every identifier of the set, with all hit bits set.
- R9: Two disjoint sets return zero hits.
- R10: For K=8, the sets {1,2,4,9} and {2,3,5,9} return {2,9} in slots 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A pair of sets is presented this cycle |
| set_a | input | K/2*ID_W | First set, ascending, slot n at [n*ID_W +: ID_W], padded with all-ones |
| set_b | input | K/2*ID_W | Second set, same format as `set_a` |
| out_valid | output | 1 | A result is present this cycle |
| out_ids | output | K/2*ID_W | Common identifiers, ascending from slot 0, padded with all-ones |
| out_hit | output | K/2 | Per-slot flag: slot holds a common identifier |

## Verification
The riskiest overlap occurs when a genuine match on the largest legal identifier lands directly next to sentinel pairs in the same merged sequence. In that case, match detection and sentinel suppression act on neighbouring positions in the same cycle. The bench provokes this with sets that both contain the value just below the sentinel and are padded with sentinels. It also sends pairs back to back, so that a result drains while the next pair enters. A scoreboard judges every result against a software intersection computed from the same inputs: it checks the hit count, the identifiers in slot order, the sentinel padding, and the arrival cycle.

// File: rtl/bmi_pkg.sv
// Shared helpers for the intersection node: stage spacing and latency.
package bmi_pkg;

    // Compare distance of merge stage s in a network of size k.
    function automatic int unsigned stage_dist(int unsigned k, int unsigned s);
        return k >> (s + 1);
    endfunction

    // Clocks from an accepted pair to its result: merge stages plus checker.
    function automatic int unsigned node_latency(int unsigned k);
        return $clog2(k) + 1;
    endfunction

endpackage

// File: rtl/bmi_cx_stage.sv
// One registered compare-exchange stage of an ascending bitonic merge.
// Pairs element i with element i+DIST when the DIST bit of i is clear;
// the smaller value goes to the lower index. Assumes K and DIST are
// powers of two with DIST < K.
module bmi_cx_stage #(
    parameter int K    = 8,
    parameter int ID_W = 16,
    parameter int DIST = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [K-1:0][ID_W-1:0]   in_seq,
    output logic                     out_vld,
    output logic [K-1:0][ID_W-1:0]   out_seq
);

    logic [K-1:0][ID_W-1:0] exch;

    for (genvar i = 0; i < K; i++) begin : g_slot
        if (((i / DIST) % 2) == 0) begin : g_pair
            localparam int J = i + DIST;
            logic swap;
            // Decide whether this pair is out of ascending order.
            assign swap    = in_seq[i] > in_seq[J];
            assign exch[i] = swap ? in_seq[J] : in_seq[i];
            assign exch[J] = swap ? in_seq[i] : in_seq[J];
        end
    end

    // Register the exchanged sequence and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_seq <= '1;
        end else begin
            out_vld <= in_vld;
            out_seq <= exch;
        end
    end

endmodule

// File: rtl/bmi_merge_net.sv
// Bitonic merge network: concatenates set A (ascending) with set B
// reversed (descending) and sorts the K values ascending through
// log2(K) registered stages. Assumes each set is ascending on entry.
module bmi_merge_net #(
    parameter int K    = 8,
    parameter int ID_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [K/2-1:0][ID_W-1:0]    set_a,
    input  logic [K/2-1:0][ID_W-1:0]    set_b,
    output logic                        out_vld,
    output logic [K-1:0][ID_W-1:0]      out_seq
);

    localparam int HALF   = K / 2;
    localparam int STAGES = $clog2(K);

    logic [K-1:0][ID_W-1:0] seq_c [STAGES+1];
    logic                   vld_c [STAGES+1];
    logic [K-1:0][ID_W-1:0] bitonic_in;

    // Form the bitonic input: A as given, B mirrored.
    for (genvar i = 0; i < HALF; i++) begin : g_load
        assign bitonic_in[i]        = set_a[i];
        assign bitonic_in[HALF + i] = set_b[HALF - 1 - i];
    end

    assign seq_c[0] = bitonic_in;
    assign vld_c[0] = in_vld;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        bmi_cx_stage #(
            .K    (K),
            .ID_W (ID_W),
            .DIST (int'(bmi_pkg::stage_dist(K, s)))
        ) u_cx (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (vld_c[s]),
            .in_seq  (seq_c[s]),
            .out_vld (vld_c[s+1]),
            .out_seq (seq_c[s+1])
        );
    end

    assign out_vld = vld_c[STAGES];
    assign out_seq = seq_c[STAGES];

endmodule

// File: rtl/bmi_nbr_check.sv
// Neighbour checker: finds equal adjacent non-sentinel values in the
// merged ascending sequence, packs them into the low slots in order and
// registers the result. Assumes each input set had no repeats, so a
// value appears at most twice and equal pairs never overlap.
module bmi_nbr_check #(
    parameter int K    = 8,
    parameter int ID_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [K-1:0][ID_W-1:0]      in_seq,
    output logic                        out_vld,
    output logic [K/2-1:0][ID_W-1:0]    out_ids,
    output logic [K/2-1:0]              out_hit
);

    localparam int HALF = K / 2;
    localparam int IW   = $clog2(HALF);
    localparam int CW   = IW + 1;
    localparam logic [CW-1:0]   HALF_C = CW'(HALF);
    localparam logic [ID_W-1:0] SENT   = '1;

    logic [K-2:0]              pair_eq;
    logic [HALF-1:0][ID_W-1:0] ids_nxt;
    logic [HALF-1:0]           hit_nxt;

    for (genvar i = 0; i < K - 1; i++) begin : g_eq
        // Flag a genuine common value; sentinel pairs are discarded.
        assign pair_eq[i] = (in_seq[i] == in_seq[i+1]) && (in_seq[i] != SENT);
    end

    // Pack flagged values into the lowest free output slot, in order.
    always_comb begin
        logic [CW-1:0] cnt;
        cnt     = '0;
        ids_nxt = '1;
        hit_nxt = '0;
        if (in_vld) begin
            for (int i = 0; i < K - 1; i++) begin
                if (pair_eq[i] && (cnt < HALF_C)) begin
                    ids_nxt[cnt[IW-1:0]] = in_seq[i];
                    hit_nxt[cnt[IW-1:0]] = 1'b1;
                    cnt = cnt + CW'(1);
                end
            end
        end
    end

    // Register the packed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_ids <= '1;
            out_hit <= '0;
        end else begin
            out_vld <= in_vld;
            out_ids <= ids_nxt;
            out_hit <= hit_nxt;
        end
    end

endmodule

// File: rtl/bmi_node.sv
// Intersection node: merge network followed by neighbour checker.
// Accepts one pair of ascending, sentinel-padded sets per clock and
// returns their common IDs log2(K)+1 clocks later, in the same format.
// Assumes K is a power of two, K >= 4, and real IDs are below all-ones.
module bmi_node #(
    parameter int K    = 8,
    parameter int ID_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [K/2*ID_W-1:0]   set_a,
    input  logic [K/2*ID_W-1:0]   set_b,
    output logic                  out_valid,
    output logic [K/2*ID_W-1:0]   out_ids,
    output logic [K/2-1:0]        out_hit
);

    localparam int HALF = K / 2;

    logic [HALF-1:0][ID_W-1:0] a_slots;
    logic [HALF-1:0][ID_W-1:0] b_slots;
    logic [HALF-1:0][ID_W-1:0] r_slots;
    logic [K-1:0][ID_W-1:0]    merged;
    logic                      merged_vld;

    assign a_slots = set_a;
    assign b_slots = set_b;

    bmi_merge_net #(
        .K    (K),
        .ID_W (ID_W)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_valid),
        .set_a   (a_slots),
        .set_b   (b_slots),
        .out_vld (merged_vld),
        .out_seq (merged)
    );

    bmi_nbr_check #(
        .K    (K),
        .ID_W (ID_W)
    ) u_nbr (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (merged_vld),
        .in_seq  (merged),
        .out_vld (out_valid),
        .out_ids (r_slots),
        .out_hit (out_hit)
    );

    assign out_ids = r_slots;

endmodule

// File: rtl/bmi_node_chk.sv
// Property checker for bmi_node; observes ports only.
module bmi_node_chk #(
    parameter int K    = 8,
    parameter int ID_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [K/2*ID_W-1:0]   set_a,
    input logic [K/2*ID_W-1:0]   set_b,
    input logic                  out_valid,
    input logic [K/2*ID_W-1:0]   out_ids,
    input logic [K/2-1:0]        out_hit
);

    localparam int HALF = K / 2;
    localparam int LAT  = int'(bmi_pkg::node_latency(K));
    localparam logic [ID_W-1:0] SENT = '1;

    logic [LAT-1:0]  vld_sr;
    logic [HALF-1:0] pad_bad;
    logic [HALF-1:0] sent_hit;
    logic [HALF-1:0] order_bad;
    logic            unused_in;

    assign unused_in = ^{set_a, set_b};

    // Independent delay line of accepted pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_sr <= '0;
        else        vld_sr <= {vld_sr[LAT-2:0], in_valid};
    end

    for (genvar i = 0; i < HALF; i++) begin : g_slot
        assign pad_bad[i]  = !out_hit[i] && (out_ids[i*ID_W +: ID_W] != SENT);
        assign sent_hit[i] = out_hit[i] && (out_ids[i*ID_W +: ID_W] == SENT);
        if (i == 0) begin : g_first
            assign order_bad[i] = 1'b0;
        end else begin : g_rest
            assign order_bad[i] = out_hit[i] &&
                (out_ids[(i-1)*ID_W +: ID_W] >= out_ids[i*ID_W +: ID_W]);
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_hit == '0) && (out_ids == '1));

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_sr[LAT-1]);

    a_r4_hits_packed_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_hit + HALF'(1)) & out_hit) == '0);

    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        order_bad == '0);

    a_r5_pad_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        pad_bad == '0);

    a_r6_no_sentinel_hit: assert property (@(posedge clk) disable iff (!rst_n)
        sent_hit == '0);

endmodule

bind bmi_node bmi_node_chk #(
    .K    (K),
    .ID_W (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .set_a     (set_a),
    .set_b     (set_b),
    .out_valid (out_valid),
    .out_ids   (out_ids),
    .out_hit   (out_hit)
);

// File: tb/sim_bmi_node.sv
`timescale 1ns/1ps
module sim_bmi_node;

    localparam int K    = 8;
    localparam int ID_W = 16;
    localparam int HALF = K / 2;
    localparam int LAT  = 4;
    localparam logic [ID_W-1:0] SENT = '1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [HALF*ID_W-1:0] set_a = '1;
    logic [HALF*ID_W-1:0] set_b = '1;
    logic                 out_valid;
    logic [HALF*ID_W-1:0] out_ids;
    logic [HALF-1:0]      out_hit;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int sent_n = 0;
    int got_n = 0;
    bit mon_on = 1'b0;

    int qa[$];
    int qb[$];
    logic [HALF*ID_W-1:0] exp_ids_q[$];
    int                   exp_cnt_q[$];
    int                   send_cyc_q[$];
    string                lbl_q[$];

    bmi_node #(.K(K), .ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .set_a(set_a), .set_b(set_b),
        .out_valid(out_valid), .out_ids(out_ids), .out_hit(out_hit)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [HALF*ID_W-1:0] act, input logic [HALF*ID_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: present qa/qb for one cycle and push the expected result.
    task automatic drive_pair(input string lbl);
        logic [HALF*ID_W-1:0] va, vb, ve;
        int n;
        @(negedge clk);
        va = '1; vb = '1; ve = '1; n = 0;
        for (int i = 0; i < qa.size(); i++) va[i*ID_W +: ID_W] = ID_W'(qa[i]);
        for (int i = 0; i < qb.size(); i++) vb[i*ID_W +: ID_W] = ID_W'(qb[i]);
        foreach (qa[i]) begin
            foreach (qb[j]) begin
                if (qa[i] == qb[j]) begin
                    ve[n*ID_W +: ID_W] = ID_W'(qa[i]);
                    n++;
                end
            end
        end
        set_a = va; set_b = vb; in_valid = 1'b1;
        exp_ids_q.push_back(ve);
        exp_cnt_q.push_back(n);
        send_cyc_q.push_back(cyc);
        lbl_q.push_back(lbl);
        sent_n++;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            set_a = {$urandom, $urandom};
            set_b = {$urandom, $urandom};
        end
    endtask

    task automatic rand_set(ref int q[$]);
        int base, step;
        q = {};
        base = int'($urandom_range(0, 2000));
        step = int'($urandom_range(1, 3));
        for (int v = 0; v < 10; v++) begin
            if (q.size() < HALF && $urandom_range(0, 9) < 4) q.push_back(base + v * step);
        end
    endtask

    // Monitor: compare each result against the scoreboard head.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                got_n++;
                if (exp_ids_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected result", out_ids, '1);
                end else begin
                    logic [HALF*ID_W-1:0] ei;
                    int ec, sc;
                    string lb;
                    logic [HALF*ID_W-1:0] hit_m, pad_m;
                    ei = exp_ids_q.pop_front();
                    ec = exp_cnt_q.pop_front();
                    sc = send_cyc_q.pop_front();
                    lb = lbl_q.pop_front();
                    hit_m = '0;
                    for (int i = 0; i < HALF; i++)
                        if (i < ec) hit_m[i*ID_W +: ID_W] = '1;
                    pad_m = ~hit_m;
                    check(cyc - sc == LAT, "R2", {lb, " latency"},
                          HALF*ID_W'(cyc - sc), HALF*ID_W'(LAT));
                    check($countones(out_hit) == ec, {"R3 ", lb}, "hit count",
                          HALF*ID_W'($countones(out_hit)), HALF*ID_W'(ec));
                    check(((out_ids & hit_m) == (ei & hit_m)) &&
                          (out_hit == HALF'((1 << ec) - 1)),
                          {"R4 ", lb}, "common ids", out_ids, ei);
                    check((out_ids & pad_m) == (ei & pad_m), {"R5 ", lb},
                          "sentinel padding", out_ids, ei);
                end
            end else begin
                check((out_hit == '0) && (out_ids == '1), "R1", "idle outputs",
                      {out_ids[HALF*ID_W-1:HALF], out_hit}, '1 << HALF);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 50000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check((out_valid == 1'b0) && (out_hit == '0) && (out_ids == '1),
              "R1", "reset state", out_ids, '1);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        qa = {1, 2, 4, 9};      qb = {2, 3, 5, 9};      drive_pair("R10 example");
        qa = {0, 1, 2, 3};      qb = {4, 5, 6, 7};      drive_pair("R9 disjoint");
        qa = {3, 7, 100, 200};  qb = {3, 7, 100, 200};  drive_pair("R8 identical");
        qa = {};                qb = {};                drive_pair("R6 both empty");
        qa = {};                qb = {10, 20, 30, 40};  drive_pair("R6 one empty");
        qa = {5};               qb = {5};               drive_pair("R6 single with padding");
        qa = {1, 65534};        qb = {65534};           drive_pair("R6 top id beside sentinels");
        idle(2);
        qa = {8, 9, 10, 11};    qb = {1, 9, 11, 500};   drive_pair("R7 back to back a");
        qa = {1, 9, 11, 500};   qb = {1, 2, 500, 600};  drive_pair("R7 back to back b");
        qa = {42};              qb = {7, 42, 43};       drive_pair("R7 back to back c");
        idle(1);
        for (int n = 0; n < 400; n++) begin
            rand_set(qa);
            rand_set(qb);
            if ($urandom_range(0, 3) == 0) qb = qa;
            drive_pair("R7 random");
            if ($urandom_range(0, 7) == 0) idle(1);
        end
        idle(LAT + 3);
        mon_on = 1'b0;
        check((exp_ids_q.size() == 0) && (got_n == sent_n), "R2", "results per pair",
              HALF*ID_W'(got_n), HALF*ID_W'(sent_n));
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule